// File: doc/BRIEF.md
# 16-bit SEC-DED Error Detection and Correction Datapath

This block protects a 16-bit memory word with a set of check bits. On the write side, a parity tree turns the user word into eight check bits to be stored beside the data. On the read side, a second parity tree recomputes those check bits from the returned data, and XORs them with the stored check bits to form a syndrome. A decoder then matches the syndrome against the single-bit error codes. It inverts the data bit in error when correction is enabled, and it drives two active-low flags: one for correctable errors and one for uncorrectable errors.

The code is a mixed-parity, Hsiao-style code. Three of the check bits are inverted parity, so an all-zero word never stores an all-zero check byte. A width input chooses how many stored check bits take part in the decode: six, for narrow memories, or all eight. A fix input chooses between correcting and detecting only. In detect-only mode the raw memory word is passed through while the flags still report the error. All outputs are registered, with a latency of one clock.

Top module: `edac16_core`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become: `dat_out`=0, `chk_out`=0, `syn_out`=0, `ce_n`=1, `ue_n`=1.
- R2: `chk_out` holds the check byte for `wr_dat`. Check bit k is the XOR over the data bits i whose error code has bit k set, and bits 2, 3 and 7 are then inverted (odd parity). The error codes are given in R4 and R9. As an example, check bit 0 covers data bits 0, 4, 5, 6, 7, 8, 12 and 13, and check bit 3 covers data bits 0, 1, 2, 3, 4, 10, 13 and 14.
- R3: `syn_out` is the check byte recomputed from `rd_dat`, XORed with `rd_chk`. A zero syndrome leaves both flags high and passes `rd_dat` unchanged.
- R4: The single-data-bit error codes, listed from bit 0 up to bit 15, are 0Dh, 0Eh, 1Ch, 2Ch, 0Bh, 15h, 23h, 31h, 13h, 16h, 1Ah, 32h, 25h, 29h, 2Ah and 34h. When `fix_en`=1 and the syndrome equals the code of bit i, that bit is inverted on `dat_out`, `ce_n`=0 and `ue_n`=1.
- R5: When `fix_en`=0, `dat_out` equals `rd_dat` for every syndrome, and the flags behave exactly as they do with `fix_en`=1.
- R6: A syndrome with exactly one bit set is a check-bit error. It sets `ce_n`=0 and `ue_n`=1, and `dat_out` equals `rd_dat`.
- R7: A non-zero syndrome that is neither a data-bit code nor one-hot sets `ue_n`=0 and `ce_n`=1, and passes `rd_dat` unchanged. As an example, errors in data bit 4 and check bit 2 give 0Fh. The two flags are never low together.
- R8: With `wide_en`=0, stored check bits 6 and 7 are ignored. `syn_out[7:6]` is 0, and only the low six bits are decoded.
- R9: With `wide_en`=1, all eight bits are decoded. Check bit 6 also covers data bit 12 (even parity), and check bit 7 also covers data bit 11 (odd parity), so their codes become 65h and B2h. Errors in data bits 13, 12, 10 and 9 give 40h, and errors in data bits 11, 10, 9 and 8 give ADh.
- R10: A triple error that matches a single-bit code is decoded as that single error. With `wide_en`=0, errors in data bits 0 and 14 plus check bit 1 give 25h, and data bit 12 is inverted.
- R11: Every output reflects the inputs that were present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_dat | input | 16 | User word to encode |
| rd_dat | input | 16 | Data word read from memory |
| rd_chk | input | 8 | Check byte read from memory |
| wide_en | input | 1 | 1: decode all 8 check bits, 0: decode 6 |
| fix_en | input | 1 | 1: correct single data-bit errors, 0: detect only |
| chk_out | output | 8 | Generated check byte for `wr_dat` |
| dat_out | output | 16 | Corrected or raw read data |
| syn_out | output | 8 | Syndrome |
| ce_n | output | 1 | Correctable error, active low |
| ue_n | output | 1 | Uncorrectable error, active low |

## Verification
The bench injects every single data-bit error and every single check-bit error, in both widths and in both correction modes. A wrong entry in a parity mask would show up here as a wrong bit flipped, or as a correctable error reported as uncorrectable. Random double errors in both widths check that no pair aliases to a single-bit code, which would make the block miscorrect. In narrow mode the bench sets junk in stored check bits 6 and 7, which a decoder that does not mask them would report as errors. The 40h and ADh multi-bit patterns and the 25h triple alias pin down the wide-mode coverage and the required miscorrection.

// File: rtl/edac16_pkg.sv
package edac16_pkg;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int NW = 6;

  typedef logic [CW-1:0][DW-1:0] mask_t;

  // Coverage of check bits 0..5, one data-bit mask per check bit.
  localparam logic [DW-1:0] COV0 = 16'h31F1;
  localparam logic [DW-1:0] COV1 = 16'h4F52;
  localparam logic [DW-1:0] COV2 = 16'h922F;
  localparam logic [DW-1:0] COV3 = 16'h641F;
  localparam logic [DW-1:0] COV4 = 16'h8FA4;
  localparam logic [DW-1:0] COV5 = 16'hF8C8;

  function automatic mask_t build_masks(input logic [DW-1:0] cov6,
                                        input logic [DW-1:0] cov7);
    mask_t m;
    m[0] = COV0; m[1] = COV1; m[2] = COV2; m[3] = COV3;
    m[4] = COV4; m[5] = COV5; m[6] = cov6; m[7] = cov7;
    return m;
  endfunction
endpackage

// File: rtl/edac16_par_tree.sv
module edac16_par_tree #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [CW-1:0][DW-1:0] MASKS = '0,
  parameter logic [CW-1:0] ODD = '0
) (
  input  logic [DW-1:0] dat,
  output logic [CW-1:0] par
);
  for (genvar k = 0; k < CW; k++) begin : g_tree
    assign par[k] = (^(dat & MASKS[k])) ^ ODD[k];
  end
endmodule

// File: rtl/edac16_syn_gen.sv
module edac16_syn_gen #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int NW = 6,
  parameter logic [CW-1:0][DW-1:0] MASKS = '0,
  parameter logic [CW-1:0] ODD = '0
) (
  input  logic [DW-1:0] rd_dat,
  input  logic [CW-1:0] rd_chk,
  input  logic          wide_en,
  output logic [CW-1:0] syn
);
  localparam logic [CW-1:0] NARROW_KEEP = CW'((1 << NW) - 1);
  logic [CW-1:0] regen;
  logic [CW-1:0] raw;

  edac16_par_tree #(.DW(DW), .CW(CW), .MASKS(MASKS), .ODD(ODD)) u_regen (
    .dat(rd_dat),
    .par(regen)
  );

  assign raw = regen ^ rd_chk;
  assign syn = wide_en ? raw : (raw & NARROW_KEEP);
endmodule

// File: rtl/edac16_syn_dec.sv
module edac16_syn_dec #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int NW = 6,
  parameter logic [CW-1:0][DW-1:0] MASKS = '0
) (
  input  logic [CW-1:0] syn,
  input  logic          wide_en,
  output logic [DW-1:0] flip,
  output logic          ce,
  output logic          ue
);
  localparam logic [CW-1:0] NARROW_KEEP = CW'((1 << NW) - 1);
  logic any_err;
  logic one_hot;

  for (genvar i = 0; i < DW; i++) begin : g_col
    logic [CW-1:0] col;
    for (genvar k = 0; k < CW; k++) begin : g_bit
      assign col[k] = MASKS[k][i];
    end
    assign flip[i] = (syn == (wide_en ? col : (col & NARROW_KEEP)));
  end

  assign any_err = |syn;
  assign one_hot = any_err && ((syn & (syn - CW'(1))) == '0);
  assign ce      = any_err && ((|flip) || one_hot);
  assign ue      = any_err && !ce;
endmodule

// File: rtl/edac16_core.sv
module edac16_core
  import edac16_pkg::*;
#(
  parameter logic [DW-1:0] COVER6 = 16'h1000,
  parameter logic [DW-1:0] COVER7 = 16'h0800,
  parameter logic [CW-1:0] ODD_PAR = 8'h8C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] wr_dat,
  input  logic [DW-1:0] rd_dat,
  input  logic [CW-1:0] rd_chk,
  input  logic          wide_en,
  input  logic          fix_en,
  output logic [CW-1:0] chk_out,
  output logic [DW-1:0] dat_out,
  output logic [CW-1:0] syn_out,
  output logic          ce_n,
  output logic          ue_n
);
  localparam mask_t MASKS = build_masks(COVER6, COVER7);

  logic [CW-1:0] gen_chk;
  logic [CW-1:0] syn;
  logic [DW-1:0] flip;
  logic          ce, ue;
  logic          pipe_vld;

  edac16_par_tree #(.DW(DW), .CW(CW), .MASKS(MASKS), .ODD(ODD_PAR)) u_enc (
    .dat(wr_dat),
    .par(gen_chk)
  );

  edac16_syn_gen #(.DW(DW), .CW(CW), .NW(NW), .MASKS(MASKS), .ODD(ODD_PAR)) u_syn (
    .rd_dat (rd_dat),
    .rd_chk (rd_chk),
    .wide_en(wide_en),
    .syn    (syn)
  );

  edac16_syn_dec #(.DW(DW), .CW(CW), .NW(NW), .MASKS(MASKS)) u_dec (
    .syn    (syn),
    .wide_en(wide_en),
    .flip   (flip),
    .ce     (ce),
    .ue     (ue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_out  <= '0;
      dat_out  <= '0;
      syn_out  <= '0;
      ce_n     <= 1'b1;
      ue_n     <= 1'b1;
      pipe_vld <= 1'b0;
    end else begin
      chk_out  <= gen_chk;
      dat_out  <= fix_en ? (rd_dat ^ flip) : rd_dat;
      syn_out  <= syn;
      ce_n     <= !ce;
      ue_n     <= !ue;
      pipe_vld <= 1'b1;
    end
  end

  // R7: the two flags are never low together
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!ce_n && !ue_n));

  // R3: a zero syndrome keeps both flags inactive
  p_zero_syn_r3: assert property (@(posedge clk) disable iff (rst)
    (syn_out == '0) |-> (ce_n && ue_n));

  // R5: detect-only mode passes the raw word through
  p_detect_raw_r5: assert property (@(posedge clk) disable iff (rst)
    (pipe_vld && !$past(fix_en)) |-> (dat_out == $past(rd_dat)));

  // R8: narrow mode never reports syndrome bits 6 and 7
  p_narrow_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (pipe_vld && !$past(wide_en)) |-> (syn_out[CW-1:NW] == '0));

  // R6: a one-hot syndrome is a check-bit error and leaves the data alone
  p_chk_single_r6: assert property (@(posedge clk) disable iff (rst)
    (pipe_vld && $countones(syn_out) == 1) |-> (!ce_n && ue_n && dat_out == $past(rd_dat)));

  // R1: outputs sit at their reset values on the cycle after a reset
  p_reset_vals_r1: assert property (@(posedge clk)
    $past(rst) |-> (dat_out == '0 && chk_out == '0 && ce_n && ue_n));
endmodule

// File: tb/edac16_core_bench.sv
`timescale 1ns/1ps
module edac16_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] wr_dat = '0, rd_dat = '0;
  logic [7:0]  rd_chk = '0;
  logic        wide_en = 1'b0, fix_en = 1'b0;
  logic [7:0]  chk_out, syn_out;
  logic [15:0] dat_out;
  logic        ce_n, ue_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edac16_core u_edac16_core (
    .clk(clk), .rst(rst), .wr_dat(wr_dat), .rd_dat(rd_dat), .rd_chk(rd_chk),
    .wide_en(wide_en), .fix_en(fix_en), .chk_out(chk_out), .dat_out(dat_out),
    .syn_out(syn_out), .ce_n(ce_n), .ue_n(ue_n)
  );

  // Reference: error code of data bit i, from R4 and R9
  function automatic logic [7:0] code_of(int i, bit wide);
    logic [7:0] t[16] = '{8'h0D, 8'h0E, 8'h1C, 8'h2C, 8'h0B, 8'h15, 8'h23, 8'h31,
                          8'h13, 8'h16, 8'h1A, 8'h32, 8'h25, 8'h29, 8'h2A, 8'h34};
    logic [7:0] c = t[i];
    if (wide && i == 12) c = c | 8'h40;
    if (wide && i == 11) c = c | 8'h80;
    return c;
  endfunction

  function automatic logic [7:0] ref_enc(logic [15:0] d);
    logic [7:0] c = 8'h8C;
    for (int i = 0; i < 16; i++)
      if (d[i]) c = c ^ code_of(i, 1'b1);
    return c;
  endfunction

  function automatic logic [7:0] ref_syn(logic [15:0] d, logic [7:0] s, bit wide);
    logic [7:0] x = ref_enc(d) ^ s;
    return wide ? x : (x & 8'h3F);
  endfunction

  task automatic chk1(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive, let the edge register them, compare at the next falling edge (R11)
  task automatic step(string tag, logic [15:0] w, logic [15:0] d, logic [7:0] s,
                      bit wide, bit fix);
    logic [7:0] sy;
    logic [15:0] ed;
    int hits;
    bit ce, ue;
    wr_dat = w; rd_dat = d; rd_chk = s; wide_en = wide; fix_en = fix;
    sy = ref_syn(d, s, wide);
    ed = d; hits = 0;
    for (int i = 0; i < 16; i++)
      if (sy == (wide ? code_of(i, 1'b1) : code_of(i, 1'b0))) begin
        hits++;
        if (fix) ed[i] = ~ed[i];
      end
    ce = (sy != 0) && (hits > 0 || $countones(sy) == 1);
    ue = (sy != 0) && !ce;
    @(posedge clk);
    @(negedge clk);
    chk1(tag, "chk_out R2 R11", chk_out, ref_enc(w));
    chk1(tag, "syn_out", syn_out, sy);
    chk1(tag, "dat_out", dat_out, ed);
    chk1(tag, "ce_n", ce_n, !ce);
    chk1(tag, "ue_n", ue_n, !ue);
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0] c;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk1("R1", "dat_out", dat_out, 0);
    chk1("R1", "chk_out", chk_out, 0);
    chk1("R1", "syn_out", syn_out, 0);
    chk1("R1", "ce_n", ce_n, 1);
    chk1("R1", "ue_n", ue_n, 1);
    rst = 1'b0;

    // R2 R3: clean words, both widths
    step("R2_R3", 16'h0000, 16'h0000, ref_enc(16'h0000), 1, 1);
    chk1("R2", "zero word check byte", chk_out, 8'h8C);
    step("R2_R3", 16'hFFFF, 16'hFFFF, ref_enc(16'hFFFF), 0, 1);
    step("R2_R3", 16'hA5C3, 16'h1234, ref_enc(16'h1234), 1, 1);

    // R4 R5: every single data-bit error, both widths, fix on/off
    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 2; f++)
        for (int i = 0; i < 16; i++) begin
          d = 16'h5A3C ^ 16'(i * 16'h0731);
          c = ref_enc(d);
          step(f ? "R4" : "R5", d, d ^ (16'h1 << i), c, w[0], f[0]);
        end

    // R6: every single check-bit error
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < (w ? 8 : 6); k++) begin
        d = 16'hC0DE ^ 16'(k);
        step("R6", d, d, ref_enc(d) ^ (8'h1 << k), w[0], 1);
      end

    // R7: example double and random doubles
    d = 16'h0F0F;
    step("R7", d, d ^ 16'h0010, ref_enc(d) ^ 8'h04, 1, 1);
    chk1("R7", "syndrome of D4+C2", syn_out, 8'h0F);
    for (int n = 0; n < 60; n++) begin
      int np, a, b;
      bit wide = n[0];
      logic [15:0] dd;
      logic [7:0] cc;
      np = wide ? 24 : 22;
      a = int'($urandom % np);
      b = int'($urandom % (np - 1));
      if (b >= a) b++;
      d = 16'($urandom);
      dd = d; cc = ref_enc(d);
      if (a < 16) dd[a] = ~dd[a]; else cc[a-16] = ~cc[a-16];
      if (b < 16) dd[b] = ~dd[b]; else cc[b-16] = ~cc[b-16];
      step("R7", d, dd, cc, wide, 1);
      chk1("R7", "double ue_n", ue_n, 0);
      chk1("R7", "double ce_n", ce_n, 1);
    end

    // R8: junk in stored bits 6 and 7 ignored in narrow mode
    d = 16'h7E81;
    step("R8", d, d, ref_enc(d) ^ 8'hC0, 0, 1);
    chk1("R8", "ce_n clean", ce_n, 1);
    chk1("R8", "ue_n clean", ue_n, 1);
    chk1("R8", "dat_out clean", dat_out, d);

    // R9: wide-mode multi-bit examples
    d = 16'h3333;
    step("R9", d, d ^ 16'h3600, ref_enc(d), 1, 1);
    chk1("R9", "syndrome 40h", syn_out, 8'h40);
    step("R9", d, d ^ 16'h0F00, ref_enc(d), 1, 1);
    chk1("R9", "syndrome ADh", syn_out, 8'hAD);

    // R10: triple alias decoded as bit 12
    d = 16'h0000;
    step("R10", d, 16'h4001, ref_enc(d) ^ 8'h02, 0, 1);
    chk1("R10", "syndrome 25h", syn_out, 8'h25);
    chk1("R10", "miscorrected word", dat_out, 16'h5001);
    chk1("R10", "ce_n", ce_n, 0);

    // R1: reset again mid-run
    rd_dat = 16'hFFFF; rd_chk = 8'h00; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk1("R1", "dat_out after reset", dat_out, 0);
    chk1("R1", "ue_n after reset", ue_n, 1);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule